// File: doc/BRIEF.md
# Interrupt Source Select and Gate

This block merges two local interrupt lines into a single host interrupt. Each local line picks one of two raw event inputs: line 1 chooses between end-of-conversion and FIFO half-full, and line 2 chooses between pacer timer tick and external trigger. Each line can be set to react to a rising or a falling edge. When the chosen input reaches its active edge, the line's pending flag is set and stays set.

The host interrupt is the OR of the two lines, where each line counts only if its own enable is on, and the whole result is gated by a global enable. Software reads the control register to see which line raised the interrupt. Any write to the clear address drops both pending flags. An event that arrives in the same cycle as the clear write is kept.

The register port is byte-wide and has separate write and read addresses. Read data is combinational from the read address.

Each line holds a two-state machine:
- `LN_IDLE` means no event is pending. `LN_PEND` means an event has been latched.
- Transition *capture* (`LN_IDLE` to `LN_PEND`) is taken on a qualified edge.
- Transition *release* (`LN_PEND` to `LN_IDLE`) is taken on a clear write when no qualified edge occurs in the same cycle.
- Otherwise each state holds.

Top module: `isg_top`

## Requirements
- R1: After reset, the source register (address 0) reads 0x00, the control register (address 1) reads 0x12, and the host interrupt is low. The value 0x12 means both polarity bits are 1 and everything else is 0.
- R2: Source register bit 0 picks the line-1 input: 0 selects end-of-conversion and 1 selects FIFO half-full.
- R3: Source register bit 1 picks the line-2 input: 0 selects timer tick and 1 selects external trigger.
- R4: Control register layout: line 1 uses bits 0 (enable), 1 (polarity) and 2 (status); line 2 uses bits 3 (enable), 4 (polarity) and 5 (status); bit 6 is the global enable. A polarity bit of 1 latches status on a rising edge of the selected input. A polarity bit of 0 latches it on a falling edge.
- R5: Status bits are read-only: writes to bits 2 and 5 have no effect. Once set, a status bit stays set until a clear write.
- R6: The host interrupt is high exactly when the global enable is 1 and at least one line has both its enable bit and its status bit at 1.
- R7: With the global enable at 0, status bits still latch, but the host interrupt stays low.
- R8: A write of any data value to address 2 clears both status bits.
- R9: If a qualified edge occurs in the same cycle as a clear write, that line's status ends up set.
- R10: A write to the source register or the control register never sets a status bit by itself, even when it changes the selected input or the polarity.
- R11: Edges on the input that a line has not selected do not affect that line's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 source, 1 control, 2 clear) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| eoc_i | input | 1 | End-of-conversion event input |
| fifo_half_i | input | 1 | FIFO half-full event input |
| tick_i | input | 1 | Pacer timer tick input |
| ext_trig_i | input | 1 | External trigger input |
| host_irq_o | output | 1 | Merged host interrupt |

## Verification
The clear write and a captured edge on a line can fall in the same clock cycle. This is the race where an event could be lost.

The bench provokes it by raising the selected input in the same cycle that it drives the clear write. It does this once with both lines idle, and once with both lines pending but an edge on only one of them. It then judges the result by reading the status bits: the edged line must stay set and the other line must be cleared.

// File: rtl/isg_pkg.sv
package isg_pkg;
    localparam int unsigned ISG_ADDR_W   = 2;
    localparam int unsigned ISG_DATA_W   = 8;
    localparam int unsigned ISG_NLINES   = 2;
    localparam int unsigned ISG_LSTRIDE  = 3;

    localparam int unsigned ADDR_SRC  = 0;
    localparam int unsigned ADDR_CTRL = 1;
    localparam int unsigned ADDR_CLR  = 2;

    localparam int unsigned OFF_EN  = 0;
    localparam int unsigned OFF_POL = 1;
    localparam int unsigned OFF_ST  = 2;
    localparam int unsigned BIT_GEN = ISG_LSTRIDE * ISG_NLINES;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;
endpackage

// File: rtl/isg_regs.sv
module isg_regs
    import isg_pkg::*;
#(
    parameter int unsigned ADDR_W = ISG_ADDR_W,
    parameter int unsigned DATA_W = ISG_DATA_W,
    parameter int unsigned NL     = ISG_NLINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NL-1:0]     pend,
    output logic [DATA_W-1:0] rd_data,
    output logic [NL-1:0]     sel_q,
    output logic [NL-1:0]     en_q,
    output logic [NL-1:0]     pol_q,
    output logic              gen_q,
    output logic              clr_pulse,
    output logic              cfg_wr
);
    localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(ADDR_SRC);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ADDR_CLR);

    logic wr_src, wr_ctrl;

    assign wr_src    = wr_en && (wr_addr == A_SRC);
    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign clr_pulse = wr_en && (wr_addr == A_CLR);
    assign cfg_wr    = wr_src || wr_ctrl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            en_q  <= '0;
            pol_q <= '1;
            gen_q <= 1'b0;
        end else begin
            if (wr_src) begin
                sel_q <= wr_data[NL-1:0];
            end
            if (wr_ctrl) begin
                for (int i = 0; i < NL; i++) begin
                    en_q[i]  <= wr_data[ISG_LSTRIDE*i + OFF_EN];
                    pol_q[i] <= wr_data[ISG_LSTRIDE*i + OFF_POL];
                end
                gen_q <= wr_data[BIT_GEN];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_SRC: begin
                rd_data[NL-1:0] = sel_q;
            end
            A_CTRL: begin
                for (int i = 0; i < NL; i++) begin
                    rd_data[ISG_LSTRIDE*i + OFF_EN]  = en_q[i];
                    rd_data[ISG_LSTRIDE*i + OFF_POL] = pol_q[i];
                    rd_data[ISG_LSTRIDE*i + OFF_ST]  = pend[i];
                end
                rd_data[BIT_GEN] = gen_q;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/isg_line.sv
module isg_line
    import isg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_a,
    input  logic src_b,
    input  logic sel,
    input  logic pol,
    input  logic quiet_set,
    input  logic clr,
    output logic ev_o,
    output logic pend_o
);
    line_state_e state_q, state_d;
    logic raw, eff, prev_q, quiet_q;

    assign raw  = sel ? src_b : src_a;
    assign eff  = pol ? raw : ~raw;
    assign ev_o = eff && !prev_q && !quiet_q;

    // Edge history and one-cycle mask after a configuration write or reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            quiet_q <= 1'b1;
        end else begin
            prev_q  <= eff;
            quiet_q <= quiet_set;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: capture and release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (ev_o)          state_d = LN_PEND;
            LN_PEND: if (clr && !ev_o)  state_d = LN_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        pend_o = 1'b0;
        unique case (state_q)
            LN_IDLE: pend_o = 1'b0;
            LN_PEND: pend_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/isg_top.sv
module isg_top
    import isg_pkg::*;
#(
    parameter int unsigned ADDR_W = ISG_ADDR_W,
    parameter int unsigned DATA_W = ISG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              eoc_i,
    input  logic              fifo_half_i,
    input  logic              tick_i,
    input  logic              ext_trig_i,
    output logic              host_irq_o
);
    localparam int unsigned NL = ISG_NLINES;

    logic [NL-1:0] line_sel, line_en, line_pol, line_pend, line_event;
    logic [NL-1:0] raw_a, raw_b;
    logic          glb_en, clr_pulse, cfg_wr;
    logic          any_line;

    assign raw_a = {tick_i, eoc_i};
    assign raw_b = {ext_trig_i, fifo_half_i};

    isg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NL(NL)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .pend      (line_pend),
        .rd_data   (rd_data),
        .sel_q     (line_sel),
        .en_q      (line_en),
        .pol_q     (line_pol),
        .gen_q     (glb_en),
        .clr_pulse (clr_pulse),
        .cfg_wr    (cfg_wr)
    );

    for (genvar g = 0; g < NL; g++) begin : g_line
        isg_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_a     (raw_a[g]),
            .src_b     (raw_b[g]),
            .sel       (line_sel[g]),
            .pol       (line_pol[g]),
            .quiet_set (cfg_wr),
            .clr       (clr_pulse),
            .ev_o      (line_event[g]),
            .pend_o    (line_pend[g])
        );
    end

    always_comb begin
        any_line = 1'b0;
        for (int i = 0; i < NL; i++) begin
            any_line = any_line | (line_en[i] & line_pend[i]);
        end
    end

    assign host_irq_o = glb_en & any_line;
endmodule

// File: rtl/isg_chk.sv
module isg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_irq_o,
    input logic       gen,
    input logic [1:0] en,
    input logic [1:0] pend,
    input logic [1:0] ev,
    input logic       clr
);
    // R6
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_o |-> ((en[0] && pend[0]) || (en[1] && pend[1])));

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> !host_irq_o);

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !clr) |=> pend[0]);

    // R8
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev[0] && !ev[1]) |=> (pend == 2'b00));

    // R9
    event_kept0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> pend[0]);

    // R9
    event_kept1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev[1] |=> pend[1]);
endmodule

bind isg_top isg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_irq_o (host_irq_o),
    .gen        (glb_en),
    .en         (line_en),
    .pend       (line_pend),
    .ev         (line_event),
    .clr        (clr_pulse)
);

// File: tb/tb_isg_top.sv
module tb_isg_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] raw = '0;
    logic       host_irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isg_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .eoc_i       (raw[0]),
        .fifo_half_i (raw[1]),
        .tick_i      (raw[2]),
        .ext_trig_i  (raw[3]),
        .host_irq_o  (host_irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input int idx);
        raw[idx] = 1'b1;
        @(negedge clk);
        raw[idx] = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] st_of(input logic [7:0] c, input int line);
        return {7'd0, c[3*line+2]};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); chk("R1 src", d, 8'h00);
        rd(2'd1, d); chk("R1 ctrl", d, 8'h12);
        chk("R1 irq", {7'd0, host_irq_o}, 8'h00);

        // R2 R3 R4 R10 R11 sweep over line, source, polarity
        for (int ln = 0; ln < 2; ln++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [7:0] cv;
                    int sel_idx, oth_idx;
                    sel_idx = 2*ln + s;
                    oth_idx = 2*ln + (1 - s);
                    cv = (ln == 0) ? (8'h10 | 8'(p << 1)) : (8'h02 | 8'(p << 4));
                    wr(2'd0, 8'(s << ln));
                    wr(2'd1, cv);
                    wr(2'd2, 8'h00);
                    rd(2'd1, d); chk("R10 cfg no event", st_of(d, ln), 8'h00);
                    pulse(oth_idx);
                    rd(2'd1, d); chk("R11 unselected ignored", st_of(d, ln), 8'h00);
                    raw[sel_idx] = 1'b1;
                    @(negedge clk);
                    rd(2'd1, d); chk("R4 rising edge", st_of(d, ln), 8'(p));
                    raw[sel_idx] = 1'b0;
                    @(negedge clk);
                    rd(2'd1, d);
                    chk(ln == 0 ? "R2 line1 source latched" : "R3 line2 source latched",
                        st_of(d, ln), 8'h01);
                end
            end
        end

        // R6 R7 sweep over statuses and enables
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 8; e++) begin
                logic [7:0] cv;
                logic expi;
                cv = 8'h12 | 8'(e & 1) | 8'(((e >> 1) & 1) << 3) | 8'(((e >> 2) & 1) << 6);
                wr(2'd0, 8'h00);
                wr(2'd1, cv);
                wr(2'd2, 8'h00);
                if (s & 1) pulse(0);
                if (s & 2) pulse(2);
                expi = ((e >> 2) & 1) != 0 &&
                       ((((e & 1) != 0) && ((s & 1) != 0)) ||
                        ((((e >> 1) & 1) != 0) && ((s & 2) != 0)));
                chk("R6 irq gate", {7'd0, host_irq_o}, {7'd0, expi});
                rd(2'd1, d);
                chk("R7 status latches", d, cv | 8'((s & 1) << 2) | 8'(((s >> 1) & 1) << 5));
            end
        end

        // R5 sticky and read-only status
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h12);
        wr(2'd2, 8'h00);
        pulse(0);
        repeat (5) @(negedge clk);
        rd(2'd1, d); chk("R5 sticky", d, 8'h16);
        wr(2'd1, 8'h36);
        rd(2'd1, d); chk("R5 status write ignored", d, 8'h16);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h36);
        rd(2'd1, d); chk("R5 status not settable", d, 8'h12);

        // R8 clear with arbitrary data
        pulse(0); pulse(2);
        rd(2'd1, d); chk("R8 both set", d, 8'h36);
        wr(2'd2, 8'hA5);
        rd(2'd1, d); chk("R8 clear any data", d, 8'h12);

        // R9 event in the clear cycle
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h00; raw[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; raw[0] = 1'b0;
        @(negedge clk);
        rd(2'd1, d); chk("R9 event during clear", d, 8'h16);
        pulse(2);
        wr_en = 1'b1; wr_addr = 2'd2; raw[2] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; raw[2] = 1'b0;
        @(negedge clk);
        rd(2'd1, d); chk("R9 one line kept", d, 8'h32);

        // R10 source switch onto an already active input
        wr(2'd2, 8'h00);
        raw[1] = 1'b1;
        @(negedge clk);
        wr(2'd0, 8'h01);
        rd(2'd1, d); chk("R10 switch no event", st_of(d, 0), 8'h00);
        raw[1] = 1'b0;
        @(negedge clk);
        pulse(1);
        rd(2'd1, d); chk("R2 fifo selected", st_of(d, 0), 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule